// File: doc/BRIEF.md
# Per-Channel Protection Fault Latch

This block sits between the protection sensors of a multi-channel high-side driver and the gate control of its output stages. Every cycle it takes per-channel detections for overtemperature, temperature-back-below-hysteresis, overcurrent and open load, one shared supply-fault flag, and the on/off command of each channel. From these it decides whether each channel may conduct. It drives an active-low fault pin and keeps a sticky fault register that a serial read returns and then clears.

The overtemperature policy is chosen per channel. In latched mode a channel that overheated stays off until the fault is gone and its command is switched off and on again. In auto-restart mode the channel comes back by itself once the sensor reports the temperature is below the hysteresis point. Overcurrent is always latched and clears only on a new switch-on. Open load and supply faults are reported but never gate a channel.

All outputs are registered. An input sampled at a clock edge shows on the outputs right after that same edge.

Top module: `chan_fault_guard`

## Requirements
- R1: While reset is asserted and right after it, every `chEnable` bit is 0, `faultPinN` is 1 and `faultReg` is all zero.
- R2: A channel whose command is 1 and that has no fault and no pending latch is enabled. A channel whose command is 0 is disabled. `otDet` on a channel disables it from the edge at which it is sampled.
- R3: With `otLatchDis[c]`=0 (latched mode), channel c stays disabled after `otDet[c]` falls. It is re-enabled only when a rising edge of `chCmd[c]` (0 in the previous sampled cycle, 1 now) is sampled while `otDet[c]` is 0. A rising edge sampled while `otDet[c]` is still 1 does not clear the latch.
- R4: With `otLatchDis[c]`=1 (auto-restart mode), channel c stays disabled after an overtemperature until `otBelowHys[c]` is sampled high with `otDet[c]` low. From that edge on it follows its command again, with no command toggle needed.
- R5: `faultReg` bit 3c is the overtemperature bit, bit 3c+1 is the overcurrent/latched bit, bit 3c+2 is the open-load bit, and bit 3*NUM_CH is the supply-fault bit. A latched-mode overtemperature sets both bit 3c and bit 3c+1. An auto-restart overtemperature sets only bit 3c.
- R6: `ocDet[c]` disables channel c and latches. The latch clears only on a rising edge of `chCmd[c]` sampled while `ocDet[c]` is 0.
- R7: `faultPinN` is 0 after any edge that samples an overtemperature, overcurrent, open load or supply fault.
- R8: `faultPinN` returns to 1 by itself once overtemperature, open load and supply faults are no longer sampled. It stays 0 while an overcurrent latch or a latched-mode overtemperature latch is pending.
- R9: A `faultReg` bit, once set, stays set after its condition is gone, until a read clears it.
- R10: An edge that samples `rdStrobe`=1 clears `faultReg`, except for bits whose faults are sampled at that same edge, which are set.
- R11: Open load and supply faults never change `chEnable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chCmd | input | NUM_CH | Commanded on (1) or off (0) per channel |
| otLatchDis | input | NUM_CH | 0 = latched overtemperature, 1 = auto-restart |
| otDet | input | NUM_CH | Overtemperature detected |
| otBelowHys | input | NUM_CH | Temperature back below the hysteresis point |
| ocDet | input | NUM_CH | Overcurrent detected |
| olDet | input | NUM_CH | Open load detected |
| supplyFault | input | 1 | Over- or undervoltage on the supply |
| rdStrobe | input | 1 | Valid serial read of the fault register this cycle |
| chEnable | output | NUM_CH | Channel allowed to conduct |
| faultPinN | output | 1 | Active-low fault status pin |
| faultReg | output | 3*NUM_CH+1 | Sticky fault register |

## Verification
The bench builds the block with the default of four channels. That gives one channel to each path: latched overtemperature on channel 0, auto-restart on channel 1, overcurrent on channel 2, and open load with the supply fault on channel 3. Cross-channel effects therefore show up in the enable vector and in the 13-bit register at the same time. Four channels are enough to reach every latch-clear ordering: a toggle while the fault is still present, a toggle after it has gone, and a read that collides with a new fault.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic setOtLatch;
    logic clrOtLatch;
    logic setOtAuto;
    logic clrOtAuto;
    logic setOc;
    logic clrOc;
    logic repOt;
    logic repOc;
    logic repOl;
  } chStrb_t;

  // Block-wide strobes
  typedef struct packed {
    logic repSupply;
    logic readClr;
    logic transient;
  } glbStrb_t;

endpackage

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfg_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CH-1:0]            chCmd,
  input  logic [NUM_CH-1:0]            otLatchDis,
  input  logic [NUM_CH-1:0]            otDet,
  input  logic [NUM_CH-1:0]            otBelowHys,
  input  logic [NUM_CH-1:0]            ocDet,
  input  logic [NUM_CH-1:0]            olDet,
  input  logic                         supplyFault,
  input  logic                         rdStrobe,
  output chStrb_t [NUM_CH-1:0]         strb,
  output glbStrb_t                     glb
);

  logic [NUM_CH-1:0] cmdPrev;
  logic [NUM_CH-1:0] cmdRise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmdPrev <= '0;
    else        cmdPrev <= chCmd;
  end

  assign cmdRise = chCmd & ~cmdPrev;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_comb begin
        strb[c].setOtLatch = otDet[c] & ~otLatchDis[c];
        strb[c].clrOtLatch = cmdRise[c] & ~otDet[c];
        strb[c].setOtAuto  = otDet[c] & otLatchDis[c];
        strb[c].clrOtAuto  = otBelowHys[c] & ~otDet[c];
        strb[c].setOc      = ocDet[c];
        strb[c].clrOc      = cmdRise[c] & ~ocDet[c];
        strb[c].repOt      = otDet[c];
        strb[c].repOc      = ocDet[c] | (otDet[c] & ~otLatchDis[c]);
        strb[c].repOl      = olDet[c];
      end

      // R3: a latch clear is only issued on a sampled off-to-on command
      p_clear_needs_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strb[c].clrOtLatch |-> (chCmd[c] && !$past(chCmd[c])));
    end
  endgenerate

  always_comb begin
    glb.repSupply = supplyFault;
    glb.readClr   = rdStrobe;
    glb.transient = (|otDet) | (|olDet) | supplyFault;
  end

endmodule

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import cfg_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     chCmd,
  input  chStrb_t [NUM_CH-1:0]  strb,
  input  glbStrb_t              glb,
  output logic [NUM_CH-1:0]     chEnable,
  output logic                  faultPinN,
  output logic [3*NUM_CH:0]     faultReg
);

  localparam int REG_W = 3 * NUM_CH + 1;

  logic [NUM_CH-1:0] otLatchQ, otLatchN;
  logic [NUM_CH-1:0] otAutoQ,  otAutoN;
  logic [NUM_CH-1:0] ocQ,      ocN;
  logic [NUM_CH-1:0] enQ;
  logic [REG_W-1:0]  regQ, regN, setBits;
  logic              pinQ;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      // set has priority over clear
      assign otLatchN[c] = strb[c].setOtLatch | (otLatchQ[c] & ~strb[c].clrOtLatch);
      assign otAutoN[c]  = strb[c].setOtAuto  | (otAutoQ[c]  & ~strb[c].clrOtAuto);
      assign ocN[c]      = strb[c].setOc      | (ocQ[c]      & ~strb[c].clrOc);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          otLatchQ[c] <= 1'b0;
          otAutoQ[c]  <= 1'b0;
          ocQ[c]      <= 1'b0;
          enQ[c]      <= 1'b0;
        end else begin
          otLatchQ[c] <= otLatchN[c];
          otAutoQ[c]  <= otAutoN[c];
          ocQ[c]      <= ocN[c];
          enQ[c]      <= chCmd[c] & ~otLatchN[c] & ~otAutoN[c] & ~ocN[c];
        end
      end

      // R2: overtemperature turns the channel off at the next edge
      p_ot_gates_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strb[c].setOtLatch || strb[c].setOtAuto) |=> !enQ[c]);

      // R3: a pending latched overtemperature without a clear keeps the channel off
      p_latch_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (otLatchQ[c] && !strb[c].clrOtLatch) |=> !enQ[c]);

      // R6: overcurrent latch persists until a clear strobe
      p_oc_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ocQ[c] && !strb[c].clrOc) |=> ocQ[c]);
    end
  endgenerate

  always_comb begin
    setBits = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      setBits[3*c]   = strb[c].repOt;
      setBits[3*c+1] = strb[c].repOc;
      setBits[3*c+2] = strb[c].repOl;
    end
    setBits[REG_W-1] = glb.repSupply;
  end

  assign regN = (glb.readClr ? '0 : regQ) | setBits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regQ <= '0;
      pinQ <= 1'b1;
    end else begin
      regQ <= regN;
      pinQ <= ~(glb.transient | (|ocN) | (|otLatchN));
    end
  end

  generate
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
      // R9: sticky until read
      p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (regQ[b] && !glb.readClr) |=> regQ[b]);
      // R10: read clears a bit with no fault in the read cycle
      p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (glb.readClr && !setBits[b]) |=> !regQ[b]);
    end
  endgenerate

  assign chEnable  = enQ;
  assign faultPinN = pinQ;
  assign faultReg  = regQ;

endmodule

// File: rtl/chan_fault_guard.sv
module chan_fault_guard
  import cfg_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CH-1:0]    chCmd,
  input  logic [NUM_CH-1:0]    otLatchDis,
  input  logic [NUM_CH-1:0]    otDet,
  input  logic [NUM_CH-1:0]    otBelowHys,
  input  logic [NUM_CH-1:0]    ocDet,
  input  logic [NUM_CH-1:0]    olDet,
  input  logic                 supplyFault,
  input  logic                 rdStrobe,
  output logic [NUM_CH-1:0]    chEnable,
  output logic                 faultPinN,
  output logic [3*NUM_CH:0]    faultReg
);

  chStrb_t [NUM_CH-1:0] strb;
  glbStrb_t             glb;

  cfg_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .chCmd       (chCmd),
    .otLatchDis  (otLatchDis),
    .otDet       (otDet),
    .otBelowHys  (otBelowHys),
    .ocDet       (ocDet),
    .olDet       (olDet),
    .supplyFault (supplyFault),
    .rdStrobe    (rdStrobe),
    .strb        (strb),
    .glb         (glb)
  );

  cfg_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .chCmd     (chCmd),
    .strb      (strb),
    .glb       (glb),
    .chEnable  (chEnable),
    .faultPinN (faultPinN),
    .faultReg  (faultReg)
  );

  // R7: any sampled fault pulls the pin low at the next edge
  p_pin_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|otDet) || (|ocDet) || (|olDet) || supplyFault) |=> !faultPinN);

  // R11: open load and supply faults alone never drop an enabled, commanded channel
  p_no_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (chEnable[0] && chCmd[0] && !otDet[0] && !ocDet[0]) |=> chEnable[0]);

endmodule

// File: tb/chan_fault_guard_test.sv
module chan_fault_guard_test;

  localparam int NUM_CH = 4;
  localparam int REG_W  = 3 * NUM_CH + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_CH-1:0] chCmd = '0, otLatchDis = '0, otDet = '0, otBelowHys = '0;
  logic [NUM_CH-1:0] ocDet = '0, olDet = '0;
  logic supplyFault = 1'b0, rdStrobe = 1'b0;
  logic [NUM_CH-1:0] chEnable;
  logic faultPinN;
  logic [REG_W-1:0] faultReg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  chan_fault_guard #(.NUM_CH(NUM_CH)) uut (
    .clk(clk), .rst_n(rst_n), .chCmd(chCmd), .otLatchDis(otLatchDis),
    .otDet(otDet), .otBelowHys(otBelowHys), .ocDet(ocDet), .olDet(olDet),
    .supplyFault(supplyFault), .rdStrobe(rdStrobe),
    .chEnable(chEnable), .faultPinN(faultPinN), .faultReg(faultReg)
  );

  typedef struct packed {
    logic [3:0]  cmd;
    logic [3:0]  dis;
    logic [3:0]  ot;
    logic [3:0]  hys;
    logic [3:0]  oc;
    logic [3:0]  ol;
    logic        sup;
    logic        rd;
    logic [3:0]  expEn;
    logic        expPin;
    logic [12:0] expReg;
    logic [7:0]  req;
  } vec_t;

  // Register layout: bit 3c OT, 3c+1 OC/latched, 3c+2 OL, bit 12 supply
  localparam int NVEC = 22;
  localparam vec_t VECS [NVEC] = '{
    //  cmd   dis   ot    hys   oc    ol    sup   rd    en    pin   reg        req
    '{4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'hF,1'b1,13'h0000,8'd2},   // R2 all on
    '{4'hF,4'h0,4'h1,4'h0,4'h0,4'h0,1'b0,1'b0,4'hE,1'b0,13'h0003,8'd5},   // R5 latched OT ch0
    '{4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'hE,1'b0,13'h0003,8'd3},   // R3 holds
    '{4'hE,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'hE,1'b0,13'h0003,8'd8},   // R8 pin held
    '{4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'hF,1'b1,13'h0003,8'd3},   // R3 re-on
    '{4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,4'hF,1'b1,13'h0000,8'd10},  // R10 read
    '{4'hF,4'h2,4'h2,4'h0,4'h0,4'h0,1'b0,1'b0,4'hD,1'b0,13'h0008,8'd5},   // R5 auto OT ch1
    '{4'hF,4'h2,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'hD,1'b1,13'h0008,8'd4},   // R4 waits
    '{4'hF,4'h2,4'h0,4'h2,4'h0,4'h0,1'b0,1'b0,4'hF,1'b1,13'h0008,8'd4},   // R4 restart
    '{4'hF,4'h0,4'h0,4'h0,4'h4,4'h0,1'b0,1'b1,4'hB,1'b0,13'h0080,8'd10},  // R10 read+set
    '{4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'hB,1'b0,13'h0080,8'd6},   // R6 holds
    '{4'hF,4'h0,4'h0,4'h0,4'h0,4'h8,1'b1,1'b0,4'hB,1'b0,13'h1880,8'd11},  // R11 OL+supply
    '{4'hB,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'hB,1'b0,13'h1880,8'd9},   // R9 sticky
    '{4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'hF,1'b1,13'h1880,8'd6},   // R6 cleared
    '{4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,4'hF,1'b1,13'h0000,8'd10},  // R10
    '{4'hF,4'h0,4'h1,4'h0,4'h0,4'h0,1'b0,1'b0,4'hE,1'b0,13'h0003,8'd7},   // R7
    '{4'hE,4'h0,4'h1,4'h0,4'h0,4'h0,1'b0,1'b0,4'hE,1'b0,13'h0003,8'd3},
    '{4'hF,4'h0,4'h1,4'h0,4'h0,4'h0,1'b0,1'b0,4'hE,1'b0,13'h0003,8'd3},   // R3 rise during OT
    '{4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'hE,1'b0,13'h0003,8'd3},   // R3 no rise
    '{4'hE,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'hE,1'b0,13'h0003,8'd8},
    '{4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'hF,1'b1,13'h0003,8'd8},   // R8 released
    '{4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,4'hF,1'b1,13'h0000,8'd10}
  };

  task automatic check(input string what, input int req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input int req, input logic [3:0] en,
                          input logic pin, input logic [12:0] rg);
    check("chEnable", req, 32'(chEnable), 32'(en));
    check("faultPinN", req, 32'(faultPinN), 32'(pin));
    check("faultReg", req, 32'(faultReg), 32'(rg));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R1: state during reset
    repeat (3) @(negedge clk);
    checkAll(1, 4'h0, 1'b1, 13'h0);
    rst_n = 1'b1;
    @(negedge clk);
    checkAll(1, 4'h0, 1'b1, 13'h0);   // R1 after release, command still 0

    for (int i = 0; i < NVEC; i++) begin
      chCmd = VECS[i].cmd; otLatchDis = VECS[i].dis; otDet = VECS[i].ot;
      otBelowHys = VECS[i].hys; ocDet = VECS[i].oc; olDet = VECS[i].ol;
      supplyFault = VECS[i].sup; rdStrobe = VECS[i].rd;
      @(negedge clk);
      checkAll(int'(VECS[i].req), VECS[i].expEn, VECS[i].expPin, VECS[i].expReg);
    end

    // R2: commanding a channel off drops it without any fault
    chCmd = 4'h5; otLatchDis = '0; otDet = '0; otBelowHys = '0;
    ocDet = '0; olDet = '0; supplyFault = 1'b0; rdStrobe = 1'b0;
    @(negedge clk);
    check("chEnable off-cmd", 2, 32'(chEnable), 32'h5);

    // R4: auto mode with hysteresis high during OT stays off, returns after
    otLatchDis = 4'h1; chCmd = 4'h1; otDet = 4'h1; otBelowHys = 4'h1;
    @(negedge clk);
    check("chEnable auto during OT", 4, 32'(chEnable), 32'h1 & 32'h0);
    otDet = 4'h0;
    @(negedge clk);
    check("chEnable auto restart", 4, 32'(chEnable), 32'h1);
    check("faultReg auto OT only", 5, 32'(faultReg), 32'h0001);
    otBelowHys = 4'h0;

    // R1: reset while faults are latched returns everything to idle
    ocDet = 4'h3; otLatchDis = 4'h0; otDet = 4'h4; chCmd = 4'hF;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    checkAll(1, 4'h0, 1'b1, 13'h0);
    ocDet = '0; otDet = '0; chCmd = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkAll(1, 4'h0, 1'b1, 13'h0);

    finishRun();
  end

endmodule